// File: doc/BRIEF.md
# Cascaded Sample Address Generator

This block produces the address for a sample memory that is filled and then read back one location per system clock. Two 8-bit counter stages form the low 16 bits of the address. Each stage is enabled by the carry of the stage below it. A single toggle stage on top adds the 17th bit, so one full sweep covers 131,072 locations before the address wraps to zero.

Each stage keeps its running count apart from a holding register. The holding register is loaded on the rising edge of a separate register clock. When the register clock is tied to the system clock, the published address trails the internal count by exactly one step. A sequencer watches the terminal-count flag to learn that the last location of the sweep is on the bus. An active-low output-enable input produces the drive-enable for the three-state address bus driver.

Top module: `addr_sweep_gen`

## Requirements
- R1: While rst_ni is low, the internal count, addr_o and tc_o are all zero.
- R2: On each rising edge of clk_i with cnt_en_i high and clr_i low, the 17-bit internal count advances by one, modulo 2^17.
- R3: On a rising edge of clk_i with cnt_en_i low and clr_i low, the internal count keeps its value.
- R4: clr_i high on a rising edge of clk_i sets the whole internal count to zero, whatever cnt_en_i is.
- R5: A carry from the low 8-bit stage advances the second stage: after the count passes 0x000FF, the next value is 0x00100.
- R6: The top bit toggles when the low 16 bits wrap: after the count passes 0x0FFFF, the next value is 0x10000.
- R7: After the count passes 0x1FFFF, the next value is 0x00000.
- R8: addr_o is loaded from the internal count on each rising edge of reg_clk_i and holds its value between those edges. When reg_clk_i is tied to clk_i, addr_o shows the count from before the most recent edge.
- R9: tc_o is high exactly while addr_o equals 0x1FFFF. During continuous counting it is a one-cycle pulse.
- R10: addr_oe_o (bus drive enable, high means drive) is the inverse of out_en_ni. out_en_ni has no effect on addr_o or on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock for the counter stages |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count enable for the lowest stage |
| clr_i | input | 1 | Synchronous clear of the internal count |
| reg_clk_i | input | 1 | Clock for the holding registers |
| out_en_ni | input | 1 | Active-low address bus output enable |
| addr_o | output | 17 | Registered address |
| addr_oe_o | output | 1 | Three-state drive enable for the address bus |
| tc_o | output | 1 | Terminal count: registered address is all ones |

## Verification
Two functions can land on the same clock edge: the synchronous clear, and a count step that carries between stages. When clr_i is high at the moment the low stage is all ones, the carry must not reach the upper stage. The bench provokes this directly by clearing at count 0x000FF with the enable held high. It also applies random clears during random enable patterns. It judges the result from the published address one edge later, which must be zero and not 0x00100. The register capture and the count step also share every edge when the clocks are tied, and this is judged by the one-step lag of addr_o.

// File: rtl/addr_sweep_pkg.sv
package addr_sweep_pkg;
  localparam int unsigned STAGE_W_DEF    = 8;
  localparam int unsigned NUM_STAGES_DEF = 2;
endpackage

// File: rtl/addr_cnt_stage.sv
module addr_cnt_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_clk_i,
  input  logic         clr_i,
  input  logic         cen_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] q_o,
  output logic         rco_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (cen_i) cnt_q <= cnt_q + 1'b1;
  end

  // holding register on its own clock
  always_ff @(posedge reg_clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= cnt_q;
  end

  assign rco_o = cen_i & (&cnt_q);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/addr_msb_stage.sv
module addr_msb_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_clk_i,
  input  logic clr_i,
  input  logic cen_i,
  output logic bit_o,
  output logic q_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bit_q <= 1'b0;
    else if (clr_i) bit_q <= 1'b0;
    else if (cen_i) bit_q <= ~bit_q;
  end

  always_ff @(posedge reg_clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= bit_q;
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/addr_sweep_gen.sv
module addr_sweep_gen
  import addr_sweep_pkg::*;
#(
  parameter  int unsigned STAGE_W    = STAGE_W_DEF,
  parameter  int unsigned NUM_STAGES = NUM_STAGES_DEF,
  localparam int unsigned LOW_W      = STAGE_W * NUM_STAGES,
  localparam int unsigned ADDR_W     = LOW_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              clr_i,
  input  logic              reg_clk_i,
  input  logic              out_en_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic              tc_o
);
  logic [NUM_STAGES:0] cen_chain;
  logic [ADDR_W-1:0]   cnt_all;
  logic [ADDR_W-1:0]   addr_q;

  assign cen_chain[0] = cnt_en_i;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    addr_cnt_stage #(.W(STAGE_W)) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .reg_clk_i (reg_clk_i),
      .clr_i     (clr_i),
      .cen_i     (cen_chain[s]),
      .cnt_o     (cnt_all[s*STAGE_W +: STAGE_W]),
      .q_o       (addr_q[s*STAGE_W +: STAGE_W]),
      .rco_o     (cen_chain[s+1])
    );
  end

  // top bit toggles on full rollover of the cascaded stages
  addr_msb_stage u_msb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reg_clk_i (reg_clk_i),
    .clr_i     (clr_i),
    .cen_i     (cen_chain[NUM_STAGES]),
    .bit_o     (cnt_all[LOW_W]),
    .q_o       (addr_q[LOW_W])
  );

  assign addr_o    = addr_q;
  assign tc_o      = &addr_q;
  assign addr_oe_o = ~out_en_ni;
endmodule

// File: rtl/addr_sweep_chk.sv
module addr_sweep_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_en_i,
  input logic              clr_i,
  input logic [ADDR_W-1:0] cnt_all
);
  localparam int unsigned LOW_W = ADDR_W - 1;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !clr_i) |=> (cnt_all == $past(cnt_all) + 1'b1));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !clr_i) |=> $stable(cnt_all));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_all == '0));

  p_msb_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !clr_i && (&cnt_all[LOW_W-1:0]))
      |=> (cnt_all[LOW_W] != $past(cnt_all[LOW_W])));

  p_msb_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(&cnt_all[LOW_W-1:0]))
      |=> (cnt_all[LOW_W] == $past(cnt_all[LOW_W])));
endmodule

bind addr_sweep_gen addr_sweep_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .clr_i    (clr_i),
  .cnt_all  (cnt_all)
);

// File: tb/sim_addr_sweep_gen.sv
`timescale 1ns/1ps
module sim_addr_sweep_gen;
  localparam int unsigned AW = 17;
  localparam logic [AW-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_en = 1'b0;
  logic clr = 1'b0;
  logic out_en_n = 1'b0;
  logic tie = 1'b1;
  logic rclk_man = 1'b0;
  logic reg_clk;
  logic [AW-1:0] addr;
  logic addr_oe;
  logic tc;

  logic [AW-1:0] m_cnt, m_reg;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign reg_clk = tie ? clk : rclk_man;

  addr_sweep_gen u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .cnt_en_i  (cnt_en),
    .clr_i     (clr),
    .reg_clk_i (reg_clk),
    .out_en_ni (out_en_n),
    .addr_o    (addr),
    .addr_oe_o (addr_oe),
    .tc_o      (tc)
  );

  function automatic logic [AW-1:0] next_cnt(logic [AW-1:0] c, logic en, logic cl);
    if (cl) return '0;
    if (en) return c + 1'b1;
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, model the edge, sample at next negedge
  task automatic tick(logic en, logic cl);
    cnt_en = en;
    clr = cl;
    @(posedge clk);
    if (tie) m_reg = m_cnt;
    m_cnt = next_cnt(m_cnt, en, cl);
    @(negedge clk);
  endtask

  task automatic chk_out(string tag);
    chk(tag, 32'(addr), 32'(m_reg));
    chk({tag, " R9 tc"}, 32'(tc), 32'(m_reg == ALL1));
  endtask

  initial begin
    #(190000.0 * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_cnt = '0;
    m_reg = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", 32'(addr), 0);
    chk("R1 reset tc", 32'(tc), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10: output enable only steers the drive enable
    out_en_n = 1'b1;
    tick(1'b0, 1'b0);
    chk("R10 oe off", 32'(addr_oe), 0);
    chk_out("R10 addr unaffected");
    out_en_n = 1'b0;
    #0.1;
    chk("R10 oe on", 32'(addr_oe), 1);

    // R2 R3 R4 random enables and clears
    for (int i = 0; i < 400; i++) begin
      logic en, cl;
      en = ($urandom % 4) != 0;
      cl = ($urandom % 16) == 0;
      tick(en, cl);
      chk_out("R2 R3 R4 R8 random");
    end

    // R4 R5: clear colliding with a low-stage carry
    tick(1'b0, 1'b1);
    for (int i = 0; i < 255; i++) tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    chk_out("R4 carry edge");
    tick(1'b1, 1'b0);
    chk_out("R4 clear beats carry");
    chk("R4 clear value", 32'(addr), 0);

    // R8: separate register clock, register holds while count runs
    tie = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick(1'b1, 1'b0);
      chk_out("R8 hold between reg edges");
    end
    #0.5 rclk_man = 1'b1;
    m_reg = m_cnt;
    #0.5 rclk_man = 1'b0;
    #0.1;
    chk_out("R8 capture on reg edge");
    @(negedge clk);
    tie = 1'b1;

    // full sweep: R5 R6 R7 R9
    tick(1'b0, 1'b1);
    for (int i = 0; i < 131076; i++) begin
      tick(1'b1, 1'b0);
      chk({"R9 tc sweep"}, 32'(tc), 32'(m_reg == ALL1));
      if (m_reg == 17'h000FF || m_reg == 17'h00100) chk_out("R5 byte carry");
      if (m_reg == 17'h0FFFF || m_reg == 17'h10000) chk_out("R6 msb toggle");
      if (m_reg == ALL1 || (i > 131000 && m_reg == 17'h0)) chk_out("R7 wrap");
    end
    chk("R7 wrapped value", 32'(addr), 32'(m_reg));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule